// File: doc/BRIEF.md
# Interrupt Destination Acceptance Filter

This block sits in front of a local interrupt controller and decides, for each incoming inter-processor interrupt message, whether that controller is a target. A message carries a destination value, a mode bit that selects physical or logical addressing, and a delivery-mode code. The filter compares the destination against the controller's own physical ID, or against its logical ID in a flat or cluster model. The model is picked by a programmable format field. For each message the filter reports acceptance, a broadcast indication and an illegal-combination indication.

Physical addressing runs with either full 8-bit IDs or legacy 4-bit IDs. In both cases the all-ones value of the active width is a broadcast. The logical ID comes from its own input and is never swapped with the physical ID. When lowest-priority delivery is paired with physical addressing or with a broadcast destination, the filter flags the message as illegal and refuses it. All results are registered. They appear one cycle after the message strobe and hold until the next message arrives.

Top module: `ipi_dest_filter`

## Requirements
- R1: While reset is asserted and right after it, `res_valid`, `res_accept`, `res_bcast` and `res_illegal` are all 0.
- R2: `res_valid` is high for exactly the cycle after each cycle in which `msg_valid` is high. The three result outputs take the result of that message and keep it unchanged until the next message.
- R3: With `msg_logical`=0 and `legacy_ids`=0, a destination from 00h to FEh is accepted exactly when it equals `own_id`.
- R4: With `msg_logical`=0 and `legacy_ids`=0, destination FFh is accepted whatever `own_id` holds, and `res_bcast`=1.
- R5: With `msg_logical`=0 and `legacy_ids`=1, only bits 3:0 of the destination and of `own_id` are compared, and bits 7:4 are ignored. A low nibble of Fh is a broadcast that is accepted, with `res_bcast`=1. `legacy_ids` has no effect in logical mode.
- R6: With `msg_logical`=1 and `fmt_model`=1111b (flat), the message is accepted exactly when `msg_dest & ldr_id` is nonzero. `own_id` takes no part in this.
- R7: With `msg_logical`=1 and `fmt_model`=0000b (cluster), the message is accepted exactly when the low nibble of `msg_dest & ldr_id` is nonzero and the destination's upper nibble either equals `ldr_id[7:4]` or is Fh.
- R8: In logical mode with any other `fmt_model` code, no message is accepted. `res_bcast` still reports destination FFh.
- R9: Delivery code 001b means lowest priority. Paired with physical mode, or with a broadcast destination in either mode, it gives `res_illegal`=1 and `res_accept`=0. In logical mode with a destination that is not a broadcast, it is legal.
- R10: With `sw_enable`=0, `res_accept` is 0. `res_bcast` and `res_illegal` are still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_enable | input | 1 | Controller software enable |
| msg_valid | input | 1 | Message strobe, one cycle per message |
| msg_dest | input | 8 | Message destination value |
| msg_logical | input | 1 | Destination mode: 0 physical, 1 logical |
| msg_dlv | input | 3 | Delivery-mode code (001b = lowest priority) |
| own_id | input | 8 | Controller physical ID |
| ldr_id | input | 8 | Controller logical ID |
| fmt_model | input | 4 | Logical model select: 1111b flat, 0000b cluster |
| legacy_ids | input | 1 | 1 selects 4-bit physical IDs |
| res_valid | output | 1 | Result strobe, one cycle after `msg_valid` |
| res_accept | output | 1 | Message accepted |
| res_bcast | output | 1 | Destination is a broadcast |
| res_illegal | output | 1 | Unsupported delivery/destination pairing |

## Verification
The case hardest to reach is a message that passes one matcher but not the other. Examples are a logical message whose destination equals the physical ID but shares no bit with the logical ID, and a legacy physical message whose upper nibble differs while the low nibble matches. The stimulus sets `own_id` and `ldr_id` to values with disjoint bits. This way, a swap of the two registers, or a compare done at the wrong width, changes the accept result. Back-to-back strobes followed by idle gaps check that each result lands in its own cycle and then holds.

// File: rtl/ipi_filt_pkg.sv
package ipi_filt_pkg;
   localparam int unsigned DLV_W = 3;
   localparam logic [DLV_W-1:0] DLV_LOWPRI = 3'b001;
   localparam int unsigned FMT_W = 4;
   localparam logic [FMT_W-1:0] FMT_FLAT    = 4'b1111;
   localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'b0000;

   typedef struct packed {
      logic accept;
      logic bcast;
      logic illegal;
   } filt_res_t;
endpackage

// File: rtl/ipi_phys_match.sv
module ipi_phys_match #(
   parameter int unsigned DEST_W   = 8,
   parameter int unsigned LEGACY_W = 4
) (
   input  logic [DEST_W-1:0] dest,
   input  logic [DEST_W-1:0] own_id,
   input  logic              legacy,
   output logic              hit,
   output logic              bcast
);
   generate
      if (LEGACY_W == 0 || LEGACY_W >= DEST_W) begin : g_bad_w
         $error("ipi_phys_match: LEGACY_W must be between 1 and DEST_W-1");
      end
   endgenerate

   logic hit_ext, hit_leg, bc_ext, bc_leg;

   always_comb begin
      hit_ext = (dest == own_id);
      bc_ext  = &dest;
      hit_leg = (dest[LEGACY_W-1:0] == own_id[LEGACY_W-1:0]);
      bc_leg  = &dest[LEGACY_W-1:0];
      hit     = legacy ? hit_leg : hit_ext;
      bcast   = legacy ? bc_leg  : bc_ext;
   end
endmodule

// File: rtl/ipi_logic_match.sv
module ipi_logic_match
   import ipi_filt_pkg::*;
#(
   parameter int unsigned DEST_W = 8
) (
   input  logic [DEST_W-1:0] dest,
   input  logic [DEST_W-1:0] ldr_id,
   input  logic [FMT_W-1:0]  fmt,
   output logic              hit,
   output logic              bcast
);
   localparam int unsigned CL_W = DEST_W / 2;

   generate
      if (DEST_W % 2 != 0) begin : g_bad_w
         $error("ipi_logic_match: DEST_W must be even for the cluster split");
      end
   endgenerate

   // per-bit overlap lanes between destination and logical ID
   logic [DEST_W-1:0] lane;
   generate
      for (genvar b = 0; b < DEST_W; b++) begin : g_lane
         assign lane[b] = dest[b] & ldr_id[b];
      end
   endgenerate

   logic flat_hit, cl_hit, cl_any, cl_eq;

   always_comb begin
      flat_hit = |lane;
      cl_any   = &dest[DEST_W-1:CL_W];
      cl_eq    = (dest[DEST_W-1:CL_W] == ldr_id[DEST_W-1:CL_W]);
      cl_hit   = (cl_any | cl_eq) & (|lane[CL_W-1:0]);
      if (fmt == FMT_FLAT)         hit = flat_hit;
      else if (fmt == FMT_CLUSTER) hit = cl_hit;
      else                         hit = 1'b0;
      bcast = &dest;
   end
endmodule

// File: rtl/ipi_dest_filter.sv
module ipi_dest_filter
   import ipi_filt_pkg::*;
#(
   parameter int unsigned DEST_W   = 8,
   parameter int unsigned LEGACY_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_enable,
   input  logic              msg_valid,
   input  logic [DEST_W-1:0] msg_dest,
   input  logic              msg_logical,
   input  logic [DLV_W-1:0]  msg_dlv,
   input  logic [DEST_W-1:0] own_id,
   input  logic [DEST_W-1:0] ldr_id,
   input  logic [FMT_W-1:0]  fmt_model,
   input  logic              legacy_ids,
   output logic              res_valid,
   output logic              res_accept,
   output logic              res_bcast,
   output logic              res_illegal
);
   logic p_hit, p_bc, l_hit, l_bc;
   logic lowpri;
   filt_res_t nxt, cur;

   ipi_phys_match #(.DEST_W(DEST_W), .LEGACY_W(LEGACY_W)) u_phys (
      .dest   (msg_dest),
      .own_id (own_id),
      .legacy (legacy_ids),
      .hit    (p_hit),
      .bcast  (p_bc)
   );

   ipi_logic_match #(.DEST_W(DEST_W)) u_logic (
      .dest   (msg_dest),
      .ldr_id (ldr_id),
      .fmt    (fmt_model),
      .hit    (l_hit),
      .bcast  (l_bc)
   );

   always_comb begin
      lowpri      = (msg_dlv == DLV_LOWPRI);
      nxt.bcast   = msg_logical ? l_bc : p_bc;
      nxt.illegal = lowpri & (~msg_logical | nxt.bcast);
      nxt.accept  = sw_enable & ~nxt.illegal &
                    (msg_logical ? l_hit : (p_hit | p_bc));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         cur       <= '0;
      end else begin
         res_valid <= msg_valid;
         if (msg_valid) cur <= nxt;
      end
   end

   assign res_accept  = cur.accept;
   assign res_bcast   = cur.bcast;
   assign res_illegal = cur.illegal;

   // R2
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> res_valid);
   // R2
   valid_only_after_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> !res_valid);
   // R2
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> ($stable(res_accept) && $stable(res_bcast) && $stable(res_illegal)));
   // R9
   illegal_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> !res_accept);
   // R10
   disabled_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !sw_enable) |=> !res_accept);
   // R4
   phys_bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && sw_enable && !msg_logical && !legacy_ids &&
       msg_dlv != DLV_LOWPRI && (&msg_dest)) |=> (res_accept && res_bcast));
endmodule

// File: tb/ipi_dest_filter_tb.sv
`timescale 1ns/1ps
module ipi_dest_filter_tb;
   typedef struct {
      logic  acc;
      logic  bc;
      logic  ill;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_enable = 1'b1;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_dest = '0;
   logic       msg_logical = 1'b0;
   logic [2:0] msg_dlv = 3'b000;
   logic [7:0] own_id = '0;
   logic [7:0] ldr_id = '0;
   logic [3:0] fmt_model = 4'hF;
   logic       legacy_ids = 1'b0;
   logic       res_valid, res_accept, res_bcast, res_illegal;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t sb[$];
   exp_t last;
   bit   done = 0;

   always #2.5 clk = ~clk;

   ipi_dest_filter u_dut (
      .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .msg_valid(msg_valid),
      .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_dlv(msg_dlv),
      .own_id(own_id), .ldr_id(ldr_id), .fmt_model(fmt_model),
      .legacy_ids(legacy_ids), .res_valid(res_valid), .res_accept(res_accept),
      .res_bcast(res_bcast), .res_illegal(res_illegal)
   );

   // independent model written from the requirement text
   function automatic exp_t model(input logic en, input logic lg, input logic [7:0] d,
                                  input logic [2:0] dl, input logic [7:0] own,
                                  input logic [7:0] ldr, input logic [3:0] fm,
                                  input logic leg, input string rq);
      exp_t e;
      logic m, b;
      if (!lg) begin
         if (leg) begin b = (d[3:0] == 4'hF); m = b || (d[3:0] == own[3:0]); end
         else     begin b = (d == 8'hFF);     m = b || (d == own); end
      end else begin
         b = (d == 8'hFF);
         if (fm == 4'hF)      m = ((d & ldr) != 8'h00);
         else if (fm == 4'h0) m = (((d[7:4] == 4'hF) || (d[7:4] == ldr[7:4])) &&
                                   ((d[3:0] & ldr[3:0]) != 4'h0));
         else                 m = 1'b0;
      end
      e.ill = (dl == 3'b001) && (!lg || b);
      e.acc = en && !e.ill && m;
      e.bc  = b;
      e.req = rq;
      return e;
   endfunction

   task automatic send(input logic en, input logic lg, input logic [7:0] d,
                       input logic [2:0] dl, input logic [7:0] own,
                       input logic [7:0] ldr, input logic [3:0] fm,
                       input logic leg, input string rq);
      @(negedge clk);
      sw_enable = en; msg_logical = lg; msg_dest = d; msg_dlv = dl;
      own_id = own; ldr_id = ldr; fmt_model = fm; legacy_ids = leg;
      msg_valid = 1'b1;
      sb.push_back(model(en, lg, d, dl, own, ldr, fm, leg, rq));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         msg_valid = 1'b0;
         msg_dest  = ~msg_dest;
         own_id    = ~own_id;
      end
   endtask

   task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] ex);
      n_chk++;
      if (act !== ex) begin
         n_bad++;
         $display("FAIL %s: acc/bc/ill actual %b expected %b", rq, act, ex);
      end
   endtask

   // monitor: pops one expected item per result strobe
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2: result strobe with no pending message, actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            last = e;
            chk(e.req, {res_accept, res_bcast, res_illegal}, {e.acc, e.bc, e.ill});
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", {res_valid, res_accept, res_illegal}, 3'b000);
      chk("R1", {1'b0, res_bcast, 1'b0}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {res_valid, res_accept, res_bcast}, 3'b000);

      // R3 physical extended
      send(1, 0, 8'h25, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R3");
      send(1, 0, 8'h24, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R3");
      send(1, 0, 8'hFE, 3'b000, 8'hFE, 8'h10, 4'hF, 0, "R3");
      send(1, 0, 8'h05, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R3");
      // R4 physical broadcast
      send(1, 0, 8'hFF, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R4");
      send(1, 0, 8'hFF, 3'b100, 8'h00, 8'h00, 4'h0, 0, "R4");
      // R5 legacy 4-bit IDs
      send(1, 0, 8'hA5, 3'b000, 8'h35, 8'h10, 4'hF, 1, "R5");
      send(1, 0, 8'h0F, 3'b000, 8'h35, 8'h10, 4'hF, 1, "R5");
      send(1, 0, 8'h26, 3'b000, 8'h25, 8'h10, 4'hF, 1, "R5");
      send(1, 1, 8'h3F, 3'b000, 8'h25, 8'h10, 4'hF, 1, "R5");
      idle(3);
      // R2 hold after idle cycles
      chk("R2", {res_accept, res_bcast, res_illegal}, {last.acc, last.bc, last.ill});
      chk("R2", {res_valid, 2'b00}, 3'b000);
      // R6 flat logical
      send(1, 1, 8'h30, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R6");
      send(1, 1, 8'h25, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R6");
      send(1, 1, 8'h81, 3'b000, 8'h00, 8'h01, 4'hF, 0, "R6");
      // R7 cluster logical
      send(1, 1, 8'h3A, 3'b000, 8'h00, 8'h32, 4'h0, 0, "R7");
      send(1, 1, 8'h4A, 3'b000, 8'h00, 8'h32, 4'h0, 0, "R7");
      send(1, 1, 8'hF2, 3'b000, 8'h00, 8'h32, 4'h0, 0, "R7");
      send(1, 1, 8'h31, 3'b000, 8'h31, 8'h32, 4'h0, 0, "R7");
      // R8 reserved model codes
      send(1, 1, 8'hFF, 3'b000, 8'hFF, 8'hFF, 4'h5, 0, "R8");
      send(1, 1, 8'h12, 3'b000, 8'h12, 8'h12, 4'h8, 0, "R8");
      // R9 lowest-priority pairings
      send(1, 0, 8'h25, 3'b001, 8'h25, 8'h10, 4'hF, 0, "R9");
      send(1, 1, 8'hFF, 3'b001, 8'h25, 8'h10, 4'hF, 0, "R9");
      send(1, 1, 8'h10, 3'b001, 8'h25, 8'h10, 4'hF, 0, "R9");
      send(1, 0, 8'h0F, 3'b001, 8'h25, 8'h10, 4'hF, 1, "R9");
      // R10 software disable
      send(0, 0, 8'hFF, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R10");
      send(0, 1, 8'h10, 3'b000, 8'h25, 8'h10, 4'hF, 0, "R10");
      send(0, 0, 8'h25, 3'b001, 8'h25, 8'h10, 4'hF, 0, "R10");
      idle(4);
      chk("R2", {res_accept, res_bcast, res_illegal}, {last.acc, last.bc, last.ill});
      if (sb.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R2: %0d results missing, actual %0d expected 0", sb.size(), sb.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule